// File: doc/BRIEF.md
# Load-Use Hazard Interlock

This block guards a three-stage in-order integer pipeline (fetch; decode and execute; memory and writeback). Each cycle it compares the source registers read by the instruction in stage 2 against the destination of the instruction in stage 3. Some producers have their result ready only in stage 3, such as load data or the status of a store-conditional. When a stage-2 consumer needs such a result in stage 2, the block stalls stages 1 and 2 for one cycle and injects a no-op into stage 3.

Every source operand carries a role code that says where its value is consumed. An operand that only supplies store data is consumed in stage 3. A late result feeding it is therefore deferred to the store's own stage-3 cycle, with no stall. The same result feeding an address base, a branch comparison or an ALU input forces the one-cycle interlock. The block also drives the per-operand bypass selects. These choose among the register file, the early result sitting in stage 3, and the value retired by the previous stage-3 instruction.

Top module: `hzi_interlock`

## Requirements
- R1: A valid stage-2 instruction with a used source of role ALU (code 0) matching the nonzero destination of a valid, writing stage-3 instruction flagged late asserts stall_o and bubble_o in that cycle.
- R2: When no used stage-2 source index equals the stage-3 destination, stall_o and bubble_o stay low.
- R3: A late match on a source of role store-data (code 3) does not stall; in the next cycle s3_sdata_fwd_o is high, while that store occupies stage 3.
- R4: A late match on a source of role address base (code 1) stalls for one cycle.
- R5: A late match on a source of role branch compare (code 2), as with a store-conditional status feeding a branch, stalls for one cycle.
- R6: A match against a stage-3 producer not flagged late causes no stall and sets that source's bypass select to 1 (stage-3 result).
- R7: A stage-3 destination of register 0 never causes a stall or a bypass. A source index of 0 never bypasses.
- R8: A source whose use flag is low never stalls and its bypass select is 0, whatever its index.
- R9: In the cycle after a bubble, the stage-3 inputs are disregarded, so an interlock never lasts more than one cycle.
- R10: A used source matching the destination written by the previous cycle's stage-3 instruction, with no stage-3 match now, gets bypass select 2 (prior writeback). This covers the operand that stalled, in the cycle after its bubble.
- R11: With s2_valid_i low, stall_o and bubble_o stay low.
- R12: During and right after reset, stall_o, bubble_o, s3_sdata_fwd_o and all bypass selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s2_valid_i | input | 1 | Stage 2 holds an instruction |
| s2_rs_idx_i | input | NUM_SRC*AW | Source register indices, source i at [AW*i +: AW] |
| s2_rs_use_i | input | NUM_SRC | Per-source read flag |
| s2_rs_role_i | input | NUM_SRC*2 | Per-source role: 0 ALU, 1 address base, 2 branch compare, 3 store data |
| s3_valid_i | input | 1 | Stage 3 holds an instruction |
| s3_rd_idx_i | input | AW | Stage-3 destination index |
| s3_rd_wen_i | input | 1 | Stage-3 instruction writes a register |
| s3_late_i | input | 1 | Stage-3 result is produced only in stage 3 |
| stall_o | output | 1 | Hold stage 1 and stage 2 |
| bubble_o | output | 1 | Present a non-writing no-op to stage 3 |
| s2_byp_sel_o | output | NUM_SRC*2 | Per-source bypass: 0 register file, 1 stage-3 result, 2 prior writeback |
| s3_sdata_fwd_o | output | 1 | Store in stage 3 takes its data from the prior writeback |

## Verification
The bench sweeps every pair of operand roles, every pair of use flags, early and late producers, and four destination choices: register 0, each source's index, and an unrelated one. This separates role-dependent stalling from index matching, use gating and the register-0 exemption. Each sweep point continues into a second cycle with stage 2 held. That cycle shows whether the interlock released after exactly one bubble, whether the stalled operand picked up the prior writeback, and whether a deferred store-data match raised the stage-3 forward flag. Directed cases then cover an invalid stage 2, a stage 3 that keeps presenting the producer after the bubble, and register-0 sources.

// File: rtl/hzi_pkg.sv
package hzi_pkg;
  localparam int unsigned ROLE_W = 2;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [ROLE_W-1:0] {
    ROLE_ALU    = 2'd0,
    ROLE_ADDR   = 2'd1,
    ROLE_BRANCH = 2'd2,
    ROLE_SDATA  = 2'd3
  } op_role_e;

  typedef enum logic [SEL_W-1:0] {
    BYP_RF = 2'd0,
    BYP_S3 = 2'd1,
    BYP_WB = 2'd2
  } byp_sel_e;
endpackage

// File: rtl/hzi_src_match.sv
module hzi_src_match
  import hzi_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] rs_idx_i,
  input  logic          rs_use_i,
  input  op_role_e      role_i,
  input  logic          s3_live_i,
  input  logic [AW-1:0] s3_rd_i,
  input  logic          s3_wen_i,
  input  logic          s3_late_i,
  input  logic          wb_valid_i,
  input  logic [AW-1:0] wb_rd_i,
  output logic          hazard_o,
  output logic          sdata_defer_o,
  output byp_sel_e      byp_sel_o
);
  logic rs_live;
  logic s3_hit;
  logic wb_hit;

  assign rs_live = rs_use_i && (rs_idx_i != '0);
  assign s3_hit  = rs_live && s3_live_i && s3_wen_i && (s3_rd_i == rs_idx_i);
  assign wb_hit  = rs_live && wb_valid_i && (wb_rd_i == rs_idx_i);

  // store data is consumed in stage 3, so a late result is deferred, not stalled
  assign hazard_o      = s3_hit && s3_late_i && (role_i != ROLE_SDATA);
  assign sdata_defer_o = s3_hit && s3_late_i && (role_i == ROLE_SDATA);

  always_comb begin
    byp_sel_o = BYP_RF;
    if (s3_hit) begin
      if (!s3_late_i) byp_sel_o = BYP_S3;
    end else if (wb_hit) begin
      byp_sel_o = BYP_WB;
    end
  end
endmodule

// File: rtl/hzi_wb_track.sv
module hzi_wb_track #(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rec_en_i,
  input  logic [AW-1:0] rec_rd_i,
  output logic          wb_valid_o,
  output logic [AW-1:0] wb_rd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_o <= 1'b0;
      wb_rd_o    <= '0;
    end else begin
      wb_valid_o <= rec_en_i;
      if (rec_en_i) wb_rd_o <= rec_rd_i;
    end
  end
endmodule

// File: rtl/hzi_bubble_ctrl.sv
module hzi_bubble_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stall_i,
  input  logic s2_valid_i,
  input  logic sdata_defer_i,
  output logic bubble_q_o,
  output logic sdata_fwd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bubble_q_o  <= 1'b0;
      sdata_fwd_o <= 1'b0;
    end else begin
      bubble_q_o  <= stall_i;
      sdata_fwd_o <= s2_valid_i && !stall_i && sdata_defer_i;
    end
  end
endmodule

// File: rtl/hzi_interlock.sv
module hzi_interlock
  import hzi_pkg::*;
#(
  parameter int unsigned AW      = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      s2_valid_i,
  input  logic [NUM_SRC*AW-1:0]     s2_rs_idx_i,
  input  logic [NUM_SRC-1:0]        s2_rs_use_i,
  input  logic [NUM_SRC*ROLE_W-1:0] s2_rs_role_i,
  input  logic                      s3_valid_i,
  input  logic [AW-1:0]             s3_rd_idx_i,
  input  logic                      s3_rd_wen_i,
  input  logic                      s3_late_i,
  output logic                      stall_o,
  output logic                      bubble_o,
  output logic [NUM_SRC*SEL_W-1:0]  s2_byp_sel_o,
  output logic                      s3_sdata_fwd_o
);
  logic               bubble_q;
  logic               s3_live;
  logic               wb_valid;
  logic [AW-1:0]      wb_rd;
  logic [NUM_SRC-1:0] hz_vec;
  logic [NUM_SRC-1:0] defer_vec;
  logic               rec_en;

  // stage 3 holds our own bubble the cycle after a stall
  assign s3_live = s3_valid_i && !bubble_q;
  assign rec_en  = s3_live && s3_rd_wen_i && (s3_rd_idx_i != '0);

  hzi_wb_track #(.AW(AW)) i_wb_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rec_en_i  (rec_en),
    .rec_rd_i  (s3_rd_idx_i),
    .wb_valid_o(wb_valid),
    .wb_rd_o   (wb_rd)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    byp_sel_e sel;

    hzi_src_match #(.AW(AW)) i_match (
      .rs_idx_i     (s2_rs_idx_i[AW*i +: AW]),
      .rs_use_i     (s2_rs_use_i[i]),
      .role_i       (op_role_e'(s2_rs_role_i[ROLE_W*i +: ROLE_W])),
      .s3_live_i    (s3_live),
      .s3_rd_i      (s3_rd_idx_i),
      .s3_wen_i     (s3_rd_wen_i),
      .s3_late_i    (s3_late_i),
      .wb_valid_i   (wb_valid),
      .wb_rd_i      (wb_rd),
      .hazard_o     (hz_vec[i]),
      .sdata_defer_o(defer_vec[i]),
      .byp_sel_o    (sel)
    );

    assign s2_byp_sel_o[SEL_W*i +: SEL_W] = sel;

    // R10: stalled operand picks up the prior writeback after its bubble
    p_byp_after_bubble_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stall_o && hz_vec[i]) |=> (s2_byp_sel_o[SEL_W*i +: SEL_W] == BYP_WB));
  end

  assign stall_o  = s2_valid_i && (|hz_vec);
  assign bubble_o = stall_o;

  hzi_bubble_ctrl i_bubble_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stall_i      (stall_o),
    .s2_valid_i   (s2_valid_i),
    .sdata_defer_i(|defer_vec),
    .bubble_q_o   (bubble_q),
    .sdata_fwd_o  (s3_sdata_fwd_o)
  );

  p_single_bubble_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);

  p_x0_no_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s3_rd_idx_i == '0) |-> !stall_o);

  p_invalid_no_stall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s2_valid_i |-> !stall_o);

  p_sdata_no_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s3_sdata_fwd_o |-> !$past(stall_o));
endmodule

// File: tb/test_hzi_interlock.sv
`timescale 1ns/1ps
module test_hzi_interlock;
  localparam int AW = 5;
  localparam int NS = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            s2_valid = 1'b0;
  logic [NS*AW-1:0] s2_rs_idx = '0;
  logic [NS-1:0]   s2_rs_use = '0;
  logic [NS*2-1:0] s2_rs_role = '0;
  logic            s3_valid = 1'b0;
  logic [AW-1:0]   s3_rd = '0;
  logic            s3_wen = 1'b0;
  logic            s3_late = 1'b0;
  logic            stall, bubble, sdata_fwd;
  logic [NS*2-1:0] byp_sel;

  int n_cmp = 0;
  int n_bad = 0;

  bit       m_bub = 0;
  bit       m_wbv = 0;
  bit [4:0] m_wbrd = 0;
  bit       m_sfwd = 0;

  always #10 clk = ~clk;

  hzi_interlock #(.AW(AW), .NUM_SRC(NS)) i_hzi_interlock (
    .clk_i(clk), .rst_ni(rst_n), .s2_valid_i(s2_valid), .s2_rs_idx_i(s2_rs_idx),
    .s2_rs_use_i(s2_rs_use), .s2_rs_role_i(s2_rs_role), .s3_valid_i(s3_valid),
    .s3_rd_idx_i(s3_rd), .s3_rd_wen_i(s3_wen), .s3_late_i(s3_late),
    .stall_o(stall), .bubble_o(bubble), .s2_byp_sel_o(byp_sel), .s3_sdata_fwd_o(sdata_fwd)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit s2v, input bit [4:0] a, input bit [4:0] b, input bit [1:0] use_m,
                      input bit [1:0] r0, input bit [1:0] r1, input bit s3v, input bit [4:0] rd,
                      input bit wen, input bit late);
    bit live;
    bit [1:0] hz, dfr;
    int esel [2];
    bit estall;
    bit matched_unused;
    string st_tag;
    @(negedge clk);
    s2_valid = s2v; s2_rs_idx = {b, a}; s2_rs_use = use_m; s2_rs_role = {r1, r0};
    s3_valid = s3v; s3_rd = rd; s3_wen = wen; s3_late = late;
    live = s3v && !m_bub;
    hz = '0; dfr = '0; matched_unused = 0;
    st_tag = "R2";
    for (int i = 0; i < 2; i++) begin
      bit [4:0] rs;
      bit [1:0] ro;
      bit hit, wbh;
      rs = (i == 0) ? a : b;
      ro = (i == 0) ? r0 : r1;
      hit = use_m[i] && rs != 0 && live && wen && rd == rs;
      wbh = use_m[i] && rs != 0 && m_wbv && m_wbrd == rs;
      if (!use_m[i] && live && wen && rd == rs && rs != 0) matched_unused = 1;
      hz[i]  = hit && late && ro != 3;
      dfr[i] = hit && late && ro == 3;
      esel[i] = hit ? (late ? 0 : 1) : (wbh ? 2 : 0);
      if (hz[i]) st_tag = (ro == 1) ? "R4" : (ro == 2) ? "R5" : "R1";
    end
    estall = s2v && (|hz);
    if (!(|hz)) begin
      if (|dfr) st_tag = "R3";
      else if (m_bub && s3v) st_tag = "R9";
      else if (!s2v) st_tag = "R11";
      else if (s3v && rd == 0) st_tag = "R7";
      else if (matched_unused) st_tag = "R8";
    end
    #5;
    chk(st_tag, "stall", stall, estall);
    chk(st_tag, "bubble", bubble, estall);
    for (int i = 0; i < 2; i++)
      chk((esel[i] == 1) ? "R6" : (esel[i] == 2) ? "R10" : st_tag, "byp_sel",
          byp_sel[2*i +: 2], esel[i]);
    chk("R3", "sdata_fwd", sdata_fwd, m_sfwd);
    m_sfwd = s2v && !estall && (|dfr);
    m_wbv  = live && wen && rd != 0;
    if (m_wbv) m_wbrd = rd;
    m_bub  = estall;
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #35;
    chk("R12", "stall in reset", stall, 0);
    chk("R12", "sdata in reset", sdata_fwd, 0);
    chk("R12", "sel in reset", byp_sel, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    for (int r0 = 0; r0 < 4; r0++)
      for (int r1 = 0; r1 < 4; r1++)
        for (int u = 0; u < 4; u++)
          for (int lt = 0; lt < 2; lt++)
            for (int rc = 0; rc < 4; rc++) begin
              bit [4:0] rd;
              rd = (rc == 0) ? 5'd0 : (rc == 1) ? 5'd3 : (rc == 2) ? 5'd5 : 5'd9;
              step(1, 3, 5, u[1:0], r0[1:0], r1[1:0], 1, rd, 1, lt[0]);
              step(1, 3, 5, u[1:0], r0[1:0], r1[1:0], 0, 0, 0, 0);
              step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            end

    // R11: invalid stage 2
    step(0, 7, 8, 2'b11, 1, 1, 1, 7, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9: stage 3 keeps presenting the producer after the bubble
    step(1, 7, 8, 2'b01, 1, 0, 1, 7, 1, 1);
    step(1, 7, 8, 2'b01, 1, 0, 1, 7, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7: register 0 source and destination
    step(1, 0, 0, 2'b11, 0, 2, 1, 0, 1, 1);
    step(1, 0, 0, 2'b11, 0, 2, 0, 0, 0, 0);
    // R5: store-conditional status into branch compare on source 1
    step(1, 4, 6, 2'b11, 2, 2, 1, 6, 1, 1);
    step(1, 4, 6, 2'b11, 2, 2, 0, 0, 0, 0);
    // R1: wen low never matches
    step(1, 4, 6, 2'b11, 0, 0, 1, 4, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule